// File: doc/BRIEF.md
# ALU with Status and Control Flag Word

This block combines a 16-bit arithmetic/logic datapath with the processor flag word that its results feed. Two operands, a three-bit operation code and a width select go in. The result comes out combinationally in the same cycle. Six status flags are derived from that result: carry, overflow, sign, zero, nibble (auxiliary) carry and even parity. They are loaded into a registered 16-bit flag word whenever the update strobe is high at a rising clock edge. The carry-using operations take their carry or borrow input from the carry bit already stored in the flag word.

The same flag word also holds three control bits: string direction, interrupt enable and single-step trap. Software-driven set and clear strobes change these bits. Arithmetic never touches them. The operand inputs carry no stream traffic. The block accepts a new operation in every cycle with no back-pressure, so no valid/ready pair is needed. Every strobe takes effect at the edge where it is sampled.

Top module: `alu_flag_unit`

## Requirements
- R1: The arithmetic operation codes are add = 0, add-with-carry = 1, subtract = 2 and subtract-with-borrow = 3. They give a+b, a+b+CF, a-b and a-b-CF, where CF is the stored carry bit. The result is truncated to the selected width.
- R2: The logic operation codes are AND = 4, OR = 5, XOR = 6 and pass = 7. Pass returns operand a unchanged, truncated to the selected width.
- R3: When word_mode is 0, the block operates on bits 7:0 only, and result bits 15:8 read 0. When word_mode is 1, all 16 bits are used.
- R4: After an arithmetic update, CF (flag bit 0) holds the carry out of the selected width for an addition, or the borrow for a subtraction.
- R5: After an arithmetic update, OF (bit 11) is set in two cases. An addition sets it when both operands share a sign and the result sign differs. A subtraction sets it when the operand signs differ and the result sign differs from operand a.
- R6: After an update, SF (bit 7) equals result bit 7 in byte mode and result bit 15 in word mode.
- R7: After an update, ZF (bit 6) is 1 exactly when the result within the selected width is zero.
- R8: After an arithmetic update, AF (bit 4) holds the carry from bit 3 into bit 4, or the borrow from bit 4 into bit 3.
- R9: After an update, PF (bit 2) is 1 when result bits 7:0 contain an even number of ones, in both widths.
- R10: After an update with a logic or pass operation, CF, OF and AF are 0.
- R11: The status flags change only at an edge where update is high. Update never changes the control bits.
- R12: The control bits are DF (bit 10), IF (bit 9) and TF (bit 8). Each set strobe sets its bit and each clear strobe clears it. Clear wins when both are high, and the bit holds when neither is.
- R13: Reset clears the whole flag word. Bits 1, 3, 5 and 12 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 16 | Operand a |
| opb | input | 16 | Operand b |
| op | input | 3 | Operation code |
| word_mode | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| update | input | 1 | Load the six status flags from the current result |
| dir_set | input | 1 | Set direction bit |
| dir_clr | input | 1 | Clear direction bit |
| ien_set | input | 1 | Set interrupt-enable bit |
| ien_clr | input | 1 | Clear interrupt-enable bit |
| step_set | input | 1 | Set single-step trap bit |
| step_clr | input | 1 | Clear single-step trap bit |
| result | output | 16 | Combinational operation result |
| flags | output | 16 | Registered flag word |

## Verification
On every cycle, the assertions check the following:
- the status bits hold unless update is high;
- each control bit follows its set/clear strobes, with clear taking priority;
- the unused bits stay 0;
- after an update, sign, zero and parity agree with the result that was present at the update;
- a logic update clears carry, overflow and nibble carry;
- byte mode zeroes the upper result byte.

The arithmetic values themselves can only be shown by the bench's vectors, whose expected words were worked out by hand:
- carry and borrow at both widths;
- signed overflow in each direction;
- nibble carry and borrow;
- chaining of the stored carry into add-with-carry and subtract-with-borrow.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  localparam int FLAG_W = 16;
  localparam int BIT_CF = 0;
  localparam int BIT_PF = 2;
  localparam int BIT_AF = 4;
  localparam int BIT_ZF = 6;
  localparam int BIT_SF = 7;
  localparam int BIT_TF = 8;
  localparam int BIT_IF = 9;
  localparam int BIT_DF = 10;
  localparam int BIT_OF = 11;
  localparam int NUM_CTL = 3;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } status_t;

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         word_mode,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         aux,
  output logic         ovf
);
  localparam int HW = W / 2;

  logic [W:0]   a_e, b_e, sum, diff, raw;
  logic [W-1:0] lg;
  logic [4:0]   nib_sum, nib_diff;
  logic         ci, is_arith, is_sub, sa, sb, sr;

  always_comb begin
    a_e = word_mode ? {1'b0, a} : {{(W-HW+1){1'b0}}, a[HW-1:0]};
    b_e = word_mode ? {1'b0, b} : {{(W-HW+1){1'b0}}, b[HW-1:0]};
    is_arith = ~op[2];
    is_sub   = op[1];
    ci = (op == OP_ADC || op == OP_SBB) ? cin : 1'b0;
    sum  = a_e + b_e + {{W{1'b0}}, ci};
    diff = a_e - b_e - {{W{1'b0}}, ci};
    nib_sum  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, ci};
    nib_diff = {1'b0, a[3:0]} - {1'b0, b[3:0]} - {4'b0, ci};
    unique case (op)
      OP_AND:  lg = a & b;
      OP_OR:   lg = a | b;
      OP_XOR:  lg = a ^ b;
      default: lg = a;
    endcase
    if (is_arith) raw = is_sub ? diff : sum;
    else          raw = {1'b0, lg};
    if (!word_mode) raw[W:HW] = '0;
    res = raw[W-1:0];

    sa = word_mode ? a_e[W-1] : a_e[HW-1];
    sb = word_mode ? b_e[W-1] : b_e[HW-1];
    sr = word_mode ? raw[W-1] : raw[HW-1];
    if (is_arith) begin
      carry = is_sub ? (word_mode ? diff[W] : diff[HW])
                     : (word_mode ? sum[W]  : sum[HW]);
      aux   = is_sub ? nib_diff[4] : nib_sum[4];
      ovf   = is_sub ? ((sa != sb) && (sr != sa))
                     : ((sa == sb) && (sr != sa));
    end else begin
      carry = 1'b0;
      aux   = 1'b0;
      ovf   = 1'b0;
    end
  end
endmodule

// File: rtl/flag_eval.sv
module flag_eval #(
  parameter int W = 16
) (
  input  logic [W-1:0] res,
  input  logic         word_mode,
  output logic         sign,
  output logic         zero,
  output logic         parity
);
  localparam int HW = W / 2;

  always_comb begin
    sign   = word_mode ? res[W-1] : res[HW-1];
    zero   = word_mode ? (res == '0) : (res[HW-1:0] == '0);
    parity = ~^res[HW-1:0];
  end
endmodule

// File: rtl/flag_store.sv
module flag_store
  import alu_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               update,
  input  status_t            st,
  input  logic [NUM_CTL-1:0] ctl_set,
  input  logic [NUM_CTL-1:0] ctl_clr,
  output logic [FLAG_W-1:0]  flags
);
  status_t            st_q;
  logic [NUM_CTL-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '0;
    else if (update) st_q <= st;
  end

  for (genvar i = 0; i < NUM_CTL; i++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q[i] <= 1'b0;
      else if (ctl_clr[i]) ctl_q[i] <= 1'b0;
      else if (ctl_set[i]) ctl_q[i] <= 1'b1;
    end
  end

  always_comb begin
    flags = '0;
    flags[BIT_CF] = st_q.cf;
    flags[BIT_PF] = st_q.pf;
    flags[BIT_AF] = st_q.af;
    flags[BIT_ZF] = st_q.zf;
    flags[BIT_SF] = st_q.sf;
    flags[BIT_OF] = st_q.of;
    for (int i = 0; i < NUM_CTL; i++) flags[BIT_TF + i] = ctl_q[i];
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  input  logic [2:0]        op,
  input  logic              word_mode,
  input  logic              update,
  input  logic              dir_set,
  input  logic              dir_clr,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              step_set,
  input  logic              step_clr,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags
);
  logic    carry, aux, ovf, sign, zero, parity;
  status_t st;

  alu_core #(.W(W)) core_i (
    .a(opa), .b(opb), .op(alu_op_e'(op)), .word_mode(word_mode),
    .cin(flags[BIT_CF]), .res(result), .carry(carry), .aux(aux), .ovf(ovf)
  );

  flag_eval #(.W(W)) eval_i (
    .res(result), .word_mode(word_mode),
    .sign(sign), .zero(zero), .parity(parity)
  );

  always_comb begin
    st.cf = carry;
    st.pf = parity;
    st.af = aux;
    st.zf = zero;
    st.sf = sign;
    st.of = ovf;
  end

  flag_store store_i (
    .clk(clk), .rst_n(rst_n), .update(update), .st(st),
    .ctl_set({dir_set, ien_set, step_set}),
    .ctl_clr({dir_clr, ien_clr, step_clr}),
    .flags(flags)
  );
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op,
  input logic              word_mode,
  input logic              update,
  input logic              dir_set,
  input logic              dir_clr,
  input logic              ien_set,
  input logic              ien_clr,
  input logic              step_set,
  input logic              step_clr,
  input logic [15:0]       result,
  input logic [FLAG_W-1:0] flags
);
  localparam logic [15:0] UNUSED_MASK = 16'hF02A;
  localparam logic [15:0] STATUS_MASK = 16'h08D5;

  // R13
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & UNUSED_MASK) == 16'h0);

  // R12
  dir_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_clr |=> !flags[BIT_DF]);

  // R12
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_set && !dir_clr) |=> flags[BIT_DF]);

  // R12
  ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_set && !ien_clr) |=> $stable(flags[BIT_IF]));

  // R12
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_set && !step_clr) |=> $stable(flags[BIT_TF]));

  // R11
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(flags & STATUS_MASK));

  // R10
  logic_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update && op[2]) |=> (!flags[BIT_CF] && !flags[BIT_OF] && !flags[BIT_AF]));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> flags[BIT_ZF] == ($past(result) == 16'h0));

  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> flags[BIT_SF] == $past(word_mode ? result[15] : result[7]));

  // R9
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> flags[BIT_PF] == ~^$past(result[7:0]));

  // R3
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_mode |-> result[15:8] == 8'h0);
endmodule

bind alu_flag_unit alu_flag_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op(op), .word_mode(word_mode), .update(update),
  .dir_set(dir_set), .dir_clr(dir_clr), .ien_set(ien_set), .ien_clr(ien_clr),
  .step_set(step_set), .step_clr(step_clr), .result(result), .flags(flags)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] opa, opb;
  logic [2:0]  op;
  logic        word_mode, update;
  logic        dir_set, dir_clr, ien_set, ien_clr, step_set, step_clr;
  logic [15:0] result, flags;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  alu_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op),
    .word_mode(word_mode), .update(update),
    .dir_set(dir_set), .dir_clr(dir_clr), .ien_set(ien_set), .ien_clr(ien_clr),
    .step_set(step_set), .step_clr(step_clr), .result(result), .flags(flags)
  );

  // {op, word_mode, carry preset, a, b, expected result, expected flag word}
  localparam int NV = 15;
  localparam logic [68:0] VEC [NV] = '{
    {3'd0, 1'b1, 1'b0, 16'h1234, 16'h1111, 16'h2345, 16'h0000}, // R1 plain add
    {3'd0, 1'b1, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0055}, // R4 R8 R7 carry out
    {3'd0, 1'b1, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 16'h0894}, // R5 R6 overflow
    {3'd0, 1'b0, 1'b0, 16'h1280, 16'h3480, 16'h0000, 16'h0845}, // R3 R4 R5 byte
    {3'd1, 1'b1, 1'b1, 16'h00FF, 16'h0000, 16'h0100, 16'h0014}, // R1 R8 add with carry
    {3'd2, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 16'h0095}, // R4 R8 borrow
    {3'd2, 1'b1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 16'h0814}, // R5 sub overflow
    {3'd3, 1'b0, 1'b1, 16'h0050, 16'h0010, 16'h003F, 16'h0014}, // R1 R3 byte borrow-in
    {3'd3, 1'b1, 1'b1, 16'h0005, 16'h0004, 16'h0000, 16'h0044}, // R1 R7
    {3'd4, 1'b1, 1'b1, 16'hF0F0, 16'hFF0F, 16'hF000, 16'h0084}, // R2 R10 and
    {3'd5, 1'b0, 1'b0, 16'hAA01, 16'h5502, 16'h0003, 16'h0004}, // R2 R3 or
    {3'd6, 1'b1, 1'b0, 16'h1234, 16'h1234, 16'h0000, 16'h0044}, // R2 R7 xor
    {3'd7, 1'b1, 1'b0, 16'h8001, 16'hFFFF, 16'h8001, 16'h0080}, // R2 R9 pass
    {3'd7, 1'b0, 1'b0, 16'h1280, 16'h0000, 16'h0080, 16'h0080}, // R3 R6 byte pass
    {3'd6, 1'b0, 1'b0, 16'h0007, 16'h0000, 16'h0007, 16'h0000}  // R9 odd parity
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic w, input logic [15:0] a, input logic [15:0] b);
    op = o; word_mode = w; opa = a; opb = b;
    #1;
  endtask

  task automatic latch();
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
  endtask

  task automatic strobe(input logic ds, dc, is, ic, ss, sc);
    dir_set = ds; dir_clr = dc; ien_set = is; ien_clr = ic; step_set = ss; step_clr = sc;
    @(negedge clk);
    dir_set = 0; dir_clr = 0; ien_set = 0; ien_clr = 0; step_set = 0; step_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; opa = 0; opb = 0; op = 0; word_mode = 1'b1; update = 1'b0;
    dir_set = 0; dir_clr = 0; ien_set = 0; ien_clr = 0; step_set = 0; step_clr = 0;
    repeat (3) @(negedge clk);
    check("R13 reset flag word", flags, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [68:0] v;
      v = VEC[i];
      // preset the stored carry used by R1 carry-in operations
      if (v[64]) apply(3'd0, 1'b1, 16'hFFFF, 16'h0001);
      else       apply(3'd0, 1'b1, 16'h0000, 16'h0000);
      latch();
      apply(v[68:66], v[65], v[63:48], v[47:32]);
      check($sformatf("R1/R2/R3 result vec%0d", i), result, v[31:16]);
      latch();
      check($sformatf("R4..R10 flags vec%0d", i), flags, v[15:0]);
    end

    // R11: no update, flags hold although result would set carry and zero
    apply(3'd0, 1'b1, 16'hFFFF, 16'h0001);
    @(negedge clk);
    @(negedge clk);
    check("R11 status hold without update", flags, 16'h0000);

    // R12: set direction
    strobe(1, 0, 0, 0, 0, 0);
    check("R12 direction set", flags, 16'h0400);
    // R12: interrupt set and clear together, clear wins; trap set
    strobe(0, 0, 1, 1, 1, 0);
    check("R12 clear priority and trap set", flags, 16'h0500);
    // R11: arithmetic update leaves control bits alone
    latch();
    check("R11 update keeps control bits", flags, 16'h0555);
    strobe(0, 0, 1, 0, 0, 0);
    check("R12 interrupt set", flags, 16'h0755);
    check("R13 unused bits zero", flags & 16'hF02A, 16'h0000);
    // R12 hold: idle cycle
    @(negedge clk);
    check("R12 control hold", flags, 16'h0755);
    // R12 clear with simultaneous status update
    apply(3'd6, 1'b1, 16'h5A5A, 16'h5A5A);
    update = 1'b1;
    strobe(0, 1, 0, 0, 0, 1);
    update = 1'b0;
    check("R12 direction and trap clear", flags, 16'h0244);

    // R1 carry chain: byte add-with-carry after a byte carry out
    apply(3'd0, 1'b0, 16'h00F0, 16'h0010);
    latch();
    check("R4 byte carry out", flags & 16'h0001, 16'h0001);
    apply(3'd1, 1'b0, 16'h0001, 16'h0001);
    check("R1 add with stored carry", result, 16'h0003);

    // R13: reset clears the whole word mid-run
    rst_n = 1'b0;
    #1;
    check("R13 reset clears word", flags, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule